// File: doc/BRIEF.md
# Two-wire bus condition detector

This block is the line front end of a two-wire serial slave. It takes the raw clock line and data line of the bus, which are asynchronous to the system clock, and samples them through a short synchronizer chain. A minimum-width filter then rejects any level that does not hold for a programmable number of system clocks. From the two clean lines it derives single-cycle event pulses: bus start, bus stop, clock-line rising edge (carrying the data bit seen at that edge) and clock-line falling edge.

It also keeps the position of the current bit inside a byte. Each clock-line rise moves the position through 1..9, and the ninth position is flagged as the acknowledge slot. A start or a stop clears the position to 0. While the slave runs its self-timed internal write, a busy input blanks every event and holds the position at 0. A start sent during that time is therefore never seen. The protocol controller above this block consumes only the pulses and the position.

Top module: `tw_bus_cond_det`

## Requirements
- R1: A level on either line that lasts fewer than FILT_LEN system clocks produces no event pulse. A level that lasts FILT_LEN clocks or more is accepted.
- R2: An accepted line change raises its event pulse in the cycle that follows the (FILT_LEN+3)-th rising system-clock edge after the change. This delay is made of two synchronizer stages, FILT_LEN filter samples and one output register.
- R3: A falling data line while the clock line is high produces exactly one start pulse (`start_o`).
- R4: A rising data line while the clock line is high produces exactly one stop pulse (`stop_o`).
- R5: Each clock-line rise produces one `scl_rise_o` pulse, and `bit_o` then holds the filtered data level at that rise. Each clock-line fall produces one `scl_fall_o` pulse.
- R6: Data-line changes while the clock line is low produce no pulse of any kind.
- R7: `bit_pos_o` advances by one on every clock-line rise, from 1 up to 9, and wraps from 9 back to 1. `ack_slot_o` is high exactly while the position is 9.
- R8: A start or a stop sets `bit_pos_o` to 0 in the same cycle as its pulse.
- R9: While `busy` is high, no event pulse is produced and `bit_pos_o` is held at 0. This includes starts, stops and clock-line edges.
- R10: After reset, all pulses are low, `bit_pos_o` is 0 and `ack_slot_o` is low. Both lines are taken as idle-high.
- R11: Each event pulse lasts one cycle, and at most one kind of event is reported per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| busy | input | 1 | Internal write cycle running; blanks detection |
| start_o | output | 1 | Start condition pulse |
| stop_o | output | 1 | Stop condition pulse |
| scl_rise_o | output | 1 | Clock-line rising-edge pulse |
| bit_o | output | 1 | Data bit captured at the last clock-line rise |
| scl_fall_o | output | 1 | Clock-line falling-edge pulse |
| bit_pos_o | output | 4 | Bit position in byte, 0 idle, 1..9 |
| ack_slot_o | output | 1 | High while the position is 9 |

## Verification
The bench builds the block with FILT_LEN = 4. This keeps the filter short enough that the exact edge-to-pulse delay can be counted cycle by cycle. At the same time, glitches of exactly FILT_LEN-1 and FILT_LEN clocks can be driven to probe both sides of the rejection boundary. Each bus phase is held for ten clocks, well beyond the FILT_LEN+3 cycle delay, so every event settles before the next one and the bit position can be read between bits.

// File: rtl/tw_cond_pkg.sv
package tw_cond_pkg;
  localparam int POS_W = 4;
  localparam logic [POS_W-1:0] POS_IDLE = 4'd0;
  localparam logic [POS_W-1:0] POS_FIRST = 4'd1;
  localparam logic [POS_W-1:0] POS_ACK = 4'd9;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } tw_evt_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/tw_glitch_filter.sv
module tw_glitch_filter #(
  parameter int   FILT_LEN = 5,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          lvl_q;
  logic [CW-1:0] run_q;

  // the output follows only after FILT_LEN consecutive samples that differ from it
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= RST_VAL;
      run_q <= '0;
    end else if (din != lvl_q) begin
      if (run_q == LAST) begin
        lvl_q <= din;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign dout = lvl_q;
endmodule

// File: rtl/tw_event_gen.sv
module tw_event_gen
  import tw_cond_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic             busy,
  output tw_evt_t          evt_o,
  output logic             bit_o,
  output logic [POS_W-1:0] pos_o,
  output logic             ack_o
);
  logic scl_q, sda_q;
  logic scl_up, scl_dn, sda_dn_hi, sda_up_hi;
  tw_evt_t evt_d, evt_q;
  logic [POS_W-1:0] pos_d, pos_q;
  logic bit_q, ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_up    = scl_f & ~scl_q;
    scl_dn    = ~scl_f & scl_q;
    sda_dn_hi = ~sda_f & sda_q & scl_f & scl_q;
    sda_up_hi = sda_f & ~sda_q & scl_f & scl_q;

    evt_d       = '0;
    evt_d.start = sda_dn_hi & ~busy;
    evt_d.stop  = sda_up_hi & ~busy;
    evt_d.rise  = scl_up & ~busy;
    evt_d.fall  = scl_dn & ~busy;

    pos_d = pos_q;
    if (busy || evt_d.start || evt_d.stop) pos_d = POS_IDLE;
    else if (evt_d.rise) pos_d = (pos_q == POS_ACK) ? POS_FIRST : pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      pos_q <= POS_IDLE;
      ack_q <= 1'b0;
      bit_q <= 1'b1;
    end else begin
      evt_q <= evt_d;
      pos_q <= pos_d;
      ack_q <= (pos_d == POS_ACK);
      if (evt_d.rise) bit_q <= sda_f;
    end
  end

  assign evt_o = evt_q;
  assign pos_o = pos_q;
  assign ack_o = ack_q;
  assign bit_o = bit_q;
endmodule

// File: rtl/tw_bus_cond_det.sv
module tw_bus_cond_det
  import tw_cond_pkg::*;
#(
  parameter int FILT_LEN    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             busy,
  output logic             start_o,
  output logic             stop_o,
  output logic             scl_rise_o,
  output logic             bit_o,
  output logic             scl_fall_o,
  output logic [POS_W-1:0] bit_pos_o,
  output logic             ack_slot_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, synced, clean;
  tw_evt_t evt;

  assign raw = {sda_in, scl_in};

  tw_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_sync (
    .clk(clk), .rst(rst), .din(raw), .dout(synced)
  );

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    tw_glitch_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) i_filt (
      .clk(clk), .rst(rst), .din(synced[l]), .dout(clean[l])
    );
  end

  tw_event_gen i_evt (
    .clk(clk), .rst(rst),
    .scl_f(clean[0]), .sda_f(clean[1]), .busy(busy),
    .evt_o(evt), .bit_o(bit_o), .pos_o(bit_pos_o), .ack_o(ack_slot_o)
  );

  assign start_o    = evt.start;
  assign stop_o     = evt.stop;
  assign scl_rise_o = evt.rise;
  assign scl_fall_o = evt.fall;
endmodule

// File: rtl/tw_bus_cond_det_chk.sv
module tw_bus_cond_det_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       start_o,
  input logic       stop_o,
  input logic       scl_rise_o,
  input logic       scl_fall_o,
  input logic [3:0] bit_pos_o,
  input logic       ack_slot_o
);
  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));
  // R11
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  // R11
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    scl_rise_o |=> !scl_rise_o);
  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !(start_o || stop_o || scl_rise_o || scl_fall_o));
  // R9
  busy_pos_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> bit_pos_o == 4'd0);
  // R8
  cond_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (start_o || stop_o) |-> bit_pos_o == 4'd0);
  // R7
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_pos_o <= 4'd9);
  // R7
  ack_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ack_slot_o == (bit_pos_o == 4'd9));
  // R7
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_rise_o) |->
      bit_pos_o == (($past(bit_pos_o) == 4'd9) ? 4'd1 : $past(bit_pos_o) + 4'd1));
endmodule

bind tw_bus_cond_det tw_bus_cond_det_chk i_chk (
  .clk(clk), .rst(rst), .busy(busy),
  .start_o(start_o), .stop_o(stop_o),
  .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o),
  .bit_pos_o(bit_pos_o), .ack_slot_o(ack_slot_o)
);

// File: tb/test_tw_bus_cond_det.sv
module test_tw_bus_cond_det;
  localparam int F = 4;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1, busy_drv = 1'b0;
  logic start_o, stop_o, scl_rise_o, bit_o, scl_fall_o, ack_slot_o;
  logic [3:0] bit_pos_o;

  int total = 0, bad = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0, n_double = 0;
  logic [15:0] rx_bits = '0;
  logic prev_start = 1'b0, prev_rise = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tw_bus_cond_det #(.FILT_LEN(F), .SYNC_STAGES(2)) i_tw_bus_cond_det (
    .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_drv), .busy(busy_drv),
    .start_o(start_o), .stop_o(stop_o), .scl_rise_o(scl_rise_o), .bit_o(bit_o),
    .scl_fall_o(scl_fall_o), .bit_pos_o(bit_pos_o), .ack_slot_o(ack_slot_o)
  );

  // monitor, sampled away from the active edge
  always @(negedge clk) if (!rst) begin
    if (start_o) n_start++;
    if (stop_o) n_stop++;
    if (scl_fall_o) n_fall++;
    if (scl_rise_o) begin n_rise++; rx_bits = {rx_bits[14:0], bit_o}; end
    if ((start_o && prev_start) || (scl_rise_o && prev_rise)) n_double++;
    if ((int'(start_o) + int'(stop_o) + int'(scl_rise_o) + int'(scl_fall_o)) > 1) n_double++;
    prev_start = start_o;
    prev_rise = scl_rise_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic d);
    @(negedge clk);
    scl_drv = c;
    sda_drv = d;
    hold(HOLD);
  endtask

  task automatic bus_start();
    drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b0, 1'b0);
  endtask

  task automatic bus_stop();
    drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
  endtask

  task automatic send_bit(input logic b);
    drive(1'b0, b); drive(1'b1, b); drive(1'b0, b);
  endtask

  task automatic t_reset();
    chk(!start_o && !stop_o && !scl_rise_o && !scl_fall_o, "R10 pulses", 1, 0);
    chk(bit_pos_o == 4'd0, "R10 position", int'(bit_pos_o), 0);
    chk(!ack_slot_o, "R10 ack flag", int'(ack_slot_o), 0);
  endtask

  task automatic t_latency_start();
    int n = 0;
    bit seen = 1'b0;
    int s0;
    hold(HOLD);
    s0 = n_start;
    @(negedge clk);
    sda_drv = 1'b0;
    while (!seen && n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (start_o) seen = 1'b1;
    end
    chk(n == F + 3, "R2 edge-to-pulse delay", n, F + 3);
    hold(HOLD);
    chk(n_start - s0 == 1, "R3 one start", n_start - s0, 1);
    chk(bit_pos_o == 4'd0, "R8 start clears", int'(bit_pos_o), 0);
    drive(1'b0, 1'b0);
  endtask

  task automatic t_byte();
    int r0 = n_rise, f0 = n_fall;
    logic [7:0] pat = 8'hA5;
    for (int i = 7; i >= 0; i--) send_bit(pat[i]);
    chk(bit_pos_o == 4'd8, "R7 position after 8 bits", int'(bit_pos_o), 8);
    chk(!ack_slot_o, "R7 no ack flag at 8", int'(ack_slot_o), 0);
    chk(rx_bits[7:0] == pat, "R5 captured byte", int'(rx_bits[7:0]), int'(pat));
    send_bit(1'b0);
    chk(bit_pos_o == 4'd9, "R7 position at ack", int'(bit_pos_o), 9);
    chk(ack_slot_o, "R7 ack flag", int'(ack_slot_o), 1);
    chk(n_rise - r0 == 9, "R5 rise count", n_rise - r0, 9);
    chk(n_fall - f0 == 9, "R5 fall count", n_fall - f0, 9);
    send_bit(1'b1);
    chk(bit_pos_o == 4'd1, "R7 wrap to 1", int'(bit_pos_o), 1);
    chk(bit_o == 1'b1, "R5 data bit", int'(bit_o), 1);
  endtask

  task automatic t_sda_low_clock();
    int e0 = n_start + n_stop + n_rise + n_fall;
    drive(1'b0, 1'b1); drive(1'b0, 1'b0); drive(1'b0, 1'b1); drive(1'b0, 1'b0);
    chk(n_start + n_stop + n_rise + n_fall == e0, "R6 no pulse with clock low",
        n_start + n_stop + n_rise + n_fall - e0, 0);
    chk(bit_pos_o == 4'd1, "R6 position unchanged", int'(bit_pos_o), 1);
  endtask

  task automatic t_restart_stop();
    int s0, p0;
    send_bit(1'b1);
    s0 = n_start;
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    chk(n_start - s0 == 1, "R3 repeated start", n_start - s0, 1);
    chk(bit_pos_o == 4'd0, "R8 repeated start clears", int'(bit_pos_o), 0);
    drive(1'b0, 1'b0);
    send_bit(1'b0);
    send_bit(1'b1);
    p0 = n_stop;
    bus_stop();
    chk(n_stop - p0 == 1, "R4 one stop", n_stop - p0, 1);
    chk(bit_pos_o == 4'd0, "R8 stop clears", int'(bit_pos_o), 0);
  endtask

  task automatic t_glitch();
    int s0 = n_start, p0 = n_stop, f0 = n_fall, r0 = n_rise;
    hold(HOLD);
    @(negedge clk); sda_drv = 1'b0; hold(F - 1); sda_drv = 1'b1; hold(HOLD);
    chk(n_start == s0 && n_stop == p0, "R1 short data glitch ignored",
        n_start - s0 + n_stop - p0, 0);
    @(negedge clk); scl_drv = 1'b0; hold(F - 1); scl_drv = 1'b1; hold(HOLD);
    chk(n_fall == f0 && n_rise == r0, "R1 short clock glitch ignored",
        n_fall - f0 + n_rise - r0, 0);
    @(negedge clk); scl_drv = 1'b0; hold(F); scl_drv = 1'b1; hold(HOLD);
    chk(n_fall - f0 == 1 && n_rise - r0 == 1, "R1 full-width clock low accepted",
        n_fall - f0 + n_rise - r0, 2);
  endtask

  task automatic t_busy();
    int e0, s0;
    bus_stop();
    @(negedge clk); busy_drv = 1'b1;
    e0 = n_start + n_stop + n_rise + n_fall;
    bus_start();
    send_bit(1'b1);
    send_bit(1'b0);
    chk(bit_pos_o == 4'd0, "R9 position held", int'(bit_pos_o), 0);
    bus_stop();
    chk(n_start + n_stop + n_rise + n_fall == e0, "R9 no pulses while busy",
        n_start + n_stop + n_rise + n_fall - e0, 0);
    @(negedge clk); busy_drv = 1'b0;
    hold(HOLD);
    s0 = n_start;
    bus_start();
    chk(n_start - s0 == 1, "R9 start seen after busy", n_start - s0, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency_start();
    t_byte();
    t_sda_low_clock();
    t_restart_stop();
    t_glitch();
    t_busy();
    chk(n_double == 0, "R11 single-cycle exclusive pulses", n_double, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule